// File: doc/BRIEF.md
# Dual Store Queue Burst Writer

This block holds two line-sized write buffers that a processor fills one 32-bit word at a time and then pushes out to external memory as a single 32-byte burst. A word access picks its slot from address bits 5:2, so bit 5 chooses the buffer and bits 4:2 choose the word inside it. Either buffer can be read back through the same access port.

A flush request (a prefetch aimed at the buffer region) names a buffer through its own bit 5 and sends that buffer out as eight beats on a valid/ready burst port. The external start address is formed in one of two ways. In the untranslated mode, bits 25:5 come from the request and bits 28:26 come from a 3-bit high-address register that belongs to the chosen buffer. In the translated mode, the request address is already the external target and only bits 28:5 are kept. While a flush runs, the other buffer stays open for writes, and a further flush request is held off.

Top module: `sq_burst_writer`

## Requirements
- R1: After reset `busy` and `bo_valid` are 0, `pf_ready` is 1, `rd_valid` is 0, and both high-address registers hold 0.
- R2: A write (`acc_valid`=1, `acc_write`=1, accepted when `acc_ready`=1) stores `acc_wdata` in slot `acc_addr[5:2]`. Slots 0-7 form buffer 0 and slots 8-15 form buffer 1. A read (`acc_valid`=1, `acc_write`=0) is always accepted, and its slot content appears on `rd_data` with `rd_valid`=1 in the cycle after.
- R3: An accepted flush (`pf_valid` and `pf_ready`) sends buffer `pf_addr[5]` as eight beats, from word 0 up to word 7. A beat is transferred in a cycle where `bo_valid` and `bo_ready` are both 1. `bo_last` is 1 on the eighth beat only, and `busy` falls in the cycle after that beat is transferred.
- R4: With `xlate_mode`=0, `bo_addr` equals the high-address register of the chosen buffer placed in bits 28:26, joined with `pf_addr[25:5]`. All other bits are 0.
- R5: With `xlate_mode`=1, `bo_addr` equals `pf_addr` with bits 31:29 and 4:0 cleared.
- R6: While `bo_valid` is 1, `bo_addr[4:0]` is 0. When a beat is not accepted, `bo_valid`, `bo_addr` and `bo_data` stay unchanged into the next cycle.
- R7: While `busy` is 1, `pf_ready` is 0. A held flush request is taken in the first cycle after the running flush ends.
- R8: During a flush, writes to the other buffer are accepted. A write to the buffer being flushed sees `acc_ready`=0 up to and including the cycle of its last beat. Such a write goes in afterwards and does not change the data sent in the flush.
- R9: `hreg_we`=1 loads `hreg_wdata` into the high-address register chosen by `hreg_sel` (0 or 1), and leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Word access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Access address; bits 5:2 pick the slot |
| acc_wdata | input | 32 | Write data |
| acc_ready | output | 1 | Access accepted this cycle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| pf_valid | input | 1 | Flush request |
| pf_addr | input | 32 | Flush request address; bit 5 picks the buffer |
| xlate_mode | input | 1 | 1 = address already external |
| pf_ready | output | 1 | Flush request accepted this cycle |
| hreg_we | input | 1 | High-address register write |
| hreg_sel | input | 1 | Which high-address register |
| hreg_wdata | input | 3 | High-address value |
| busy | output | 1 | Flush in progress |
| bo_valid | output | 1 | Burst beat valid |
| bo_addr | output | 32 | Burst start address, 32-byte aligned |
| bo_data | output | 32 | Burst beat data |
| bo_last | output | 1 | Final beat of burst |
| bo_ready | input | 1 | Burst sink ready |

## Verification
The hardest case to reach from the ports is a write to the buffer being flushed while that flush is stalled by the sink. The write has to be held pending through every beat, including the last, and then has to land without changing the data already sent. The stimulus starts a flush and holds `bo_ready` low. It writes to the other buffer, which must be accepted, and then keeps a write to the flushing buffer asserted while the sink is released at an uneven rate. Finally it reads both buffers back. A second scenario holds a new flush request while one is running and checks that it starts as soon as the first one ends.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_BURST = 1'b1
  } seq_state_t;
endpackage

// File: rtl/sq_store.sv
// Word storage for both buffers: one write port, one access read port and
// one flush read port, all synchronous (RAM-inferable).
module sq_store #(
  parameter int DATA_W = 32,
  parameter int NWORDS = 16,
  localparam int IDX_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              fl_en,
  input  logic [IDX_W-1:0]  fl_idx,
  output logic [DATA_W-1:0] fl_data
);
  logic [DATA_W-1:0] mem [NWORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (fl_en) fl_data <= mem[fl_idx];
  end
endmodule

// File: rtl/sq_hi_regs.sv
// One high-address register per buffer.
module sq_hi_regs #(
  parameter int HI_W = 3,
  parameter int NQ   = 2,
  localparam int SEL_W = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [SEL_W-1:0]         sel,
  input  logic [HI_W-1:0]          wdata,
  output logic [NQ-1:0][HI_W-1:0]  hi_q
);
  for (genvar g = 0; g < NQ; g++) begin : g_hreg
    always_ff @(posedge clk) begin
      if (rst)                          hi_q[g] <= '0;
      else if (we && (sel == SEL_W'(g))) hi_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/sq_target.sv
// Forms the external burst start address.
module sq_target #(
  parameter int ADDR_W    = 32,
  parameter int EXT_W     = 29,
  parameter int HI_W      = 3,
  parameter int LINE_BITS = 5
) (
  input  logic [ADDR_W-1:0] pf_addr,
  input  logic              xlate,
  input  logic [HI_W-1:0]   hi,
  output logic [ADDR_W-1:0] target
);
  logic unused_pf_bits;
  assign unused_pf_bits = ^{pf_addr[ADDR_W-1:EXT_W], pf_addr[LINE_BITS-1:0]};

  always_comb begin
    target = '0;
    if (xlate) begin
      target[EXT_W-1:LINE_BITS] = pf_addr[EXT_W-1:LINE_BITS];
    end else begin
      target[EXT_W-HI_W-1:LINE_BITS] = pf_addr[EXT_W-HI_W-1:LINE_BITS];
      target[EXT_W-1:EXT_W-HI_W]     = hi;
    end
  end
endmodule

// File: rtl/sq_burst_seq.sv
// Burst sequencer: latches buffer and address, steps through the beats.
module sq_burst_seq
  import sq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int QWORDS = 8,
  localparam int BEAT_W = $clog2(QWORDS),
  localparam int IDX_W  = BEAT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_q,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              bo_ready,
  output logic              busy,
  output logic              flush_q,
  output logic [ADDR_W-1:0] bo_addr,
  output logic              bo_last,
  output logic              fl_en,
  output logic [IDX_W-1:0]  fl_idx
);
  seq_state_t        state;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] beat_nx;
  logic              fire;
  logic              at_last;

  assign busy    = (state == SEQ_BURST);
  assign beat_nx = beat + 1'b1;
  assign at_last = (beat == BEAT_W'(QWORDS - 1));
  assign fire    = busy && bo_ready;
  assign bo_last = busy && at_last;
  assign fl_en   = start || (fire && !at_last);
  assign fl_idx  = start ? {start_q, {BEAT_W{1'b0}}} : {flush_q, beat_nx};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      beat    <= '0;
      flush_q <= 1'b0;
      bo_addr <= '0;
    end else if (start) begin
      state   <= SEQ_BURST;
      beat    <= '0;
      flush_q <= start_q;
      bo_addr <= start_addr;
    end else if (fire) begin
      if (at_last) state <= SEQ_IDLE;
      else         beat  <= beat_nx;
    end
  end
endmodule

// File: rtl/sq_burst_writer.sv
module sq_burst_writer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int QWORDS = 8,
  parameter int EXT_W  = 29,
  parameter int HI_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              acc_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pf_valid,
  input  logic [ADDR_W-1:0] pf_addr,
  input  logic              xlate_mode,
  output logic              pf_ready,
  input  logic              hreg_we,
  input  logic              hreg_sel,
  input  logic [HI_W-1:0]   hreg_wdata,
  output logic              busy,
  output logic              bo_valid,
  output logic [ADDR_W-1:0] bo_addr,
  output logic [DATA_W-1:0] bo_data,
  output logic              bo_last,
  input  logic              bo_ready
);
  localparam int BYTE_BITS = $clog2(DATA_W / 8);
  localparam int BEAT_W    = $clog2(QWORDS);
  localparam int QSEL_BIT  = BYTE_BITS + BEAT_W;
  localparam int IDX_W     = BEAT_W + 1;
  localparam int NWORDS    = 2 * QWORDS;

  logic                   flush_q;
  logic                   pf_go;
  logic                   acc_q;
  logic                   blocked;
  logic                   wr_en;
  logic                   rd_en;
  logic [IDX_W-1:0]       acc_idx;
  logic [1:0][HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0]      target;
  logic                   fl_en;
  logic [IDX_W-1:0]       fl_idx;
  logic                   unused_acc_bits;

  assign unused_acc_bits = ^{acc_addr[ADDR_W-1:QSEL_BIT+1], acc_addr[BYTE_BITS-1:0]};

  assign acc_idx  = acc_addr[QSEL_BIT:BYTE_BITS];
  assign acc_q    = acc_addr[QSEL_BIT];
  assign pf_ready = !busy;
  assign pf_go    = pf_valid && pf_ready;

  // A write may not touch a buffer being flushed or about to be captured.
  assign blocked   = (busy && (acc_q == flush_q)) ||
                     (pf_go && (acc_q == pf_addr[QSEL_BIT]));
  assign acc_ready = !(acc_write && blocked);
  assign wr_en     = acc_valid && acc_write && acc_ready;
  assign rd_en     = acc_valid && !acc_write;

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_en;
  end

  sq_hi_regs #(.HI_W(HI_W), .NQ(2)) u_hregs (
    .clk   (clk),
    .rst   (rst),
    .we    (hreg_we),
    .sel   (hreg_sel),
    .wdata (hreg_wdata),
    .hi_q  (hi_q)
  );

  sq_target #(
    .ADDR_W(ADDR_W), .EXT_W(EXT_W), .HI_W(HI_W), .LINE_BITS(QSEL_BIT)
  ) u_target (
    .pf_addr (pf_addr),
    .xlate   (xlate_mode),
    .hi      (hi_q[pf_addr[QSEL_BIT]]),
    .target  (target)
  );

  sq_burst_seq #(.ADDR_W(ADDR_W), .QWORDS(QWORDS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (pf_go),
    .start_q    (pf_addr[QSEL_BIT]),
    .start_addr (target),
    .bo_ready   (bo_ready),
    .busy       (busy),
    .flush_q    (flush_q),
    .bo_addr    (bo_addr),
    .bo_last    (bo_last),
    .fl_en      (fl_en),
    .fl_idx     (fl_idx)
  );

  sq_store #(.DATA_W(DATA_W), .NWORDS(NWORDS)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (acc_idx),
    .wr_data (acc_wdata),
    .rd_en   (rd_en),
    .rd_idx  (acc_idx),
    .rd_data (rd_data),
    .fl_en   (fl_en),
    .fl_idx  (fl_idx),
    .fl_data (bo_data)
  );

  assign bo_valid = busy;
endmodule

// File: rtl/sq_burst_writer_chk.sv
module sq_burst_writer_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              pf_ready,
  input logic              bo_valid,
  input logic              bo_ready,
  input logic              bo_last,
  input logic [ADDR_W-1:0] bo_addr,
  input logic [DATA_W-1:0] bo_data,
  input logic              acc_valid,
  input logic              acc_write,
  input logic              acc_qsel,
  input logic              acc_ready,
  input logic              rd_valid,
  input logic              flush_q
);
  // R6
  aligned_addr_chk: assert property (@(posedge clk) disable iff (rst)
    bo_valid |-> (bo_addr[4:0] == 5'd0));

  // R6
  hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (bo_valid && !bo_ready) |=> (bo_valid && $stable(bo_addr) && $stable(bo_data)));

  // R7
  no_second_flush_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !pf_ready);

  // R8
  flush_write_block_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && acc_valid && acc_write && (acc_qsel == flush_q)) |-> !acc_ready);

  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> rd_valid);

  // R3
  burst_end_chk: assert property (@(posedge clk) disable iff (rst)
    (bo_valid && bo_ready && bo_last) |=> !busy);
endmodule

bind sq_burst_writer sq_burst_writer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .pf_ready  (pf_ready),
  .bo_valid  (bo_valid),
  .bo_ready  (bo_ready),
  .bo_last   (bo_last),
  .bo_addr   (bo_addr),
  .bo_data   (bo_data),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_qsel  (acc_addr[5]),
  .acc_ready (acc_ready),
  .rd_valid  (rd_valid),
  .flush_q   (flush_q)
);

// File: tb/sim_sq_burst_writer.sv
`timescale 1ns/1ps
module sim_sq_burst_writer;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid, acc_write, acc_ready, rd_valid;
  logic [31:0] acc_addr, acc_wdata, rd_data;
  logic        pf_valid, xlate_mode, pf_ready;
  logic [31:0] pf_addr;
  logic        hreg_we, hreg_sel;
  logic [2:0]  hreg_wdata;
  logic        busy, bo_valid, bo_last, bo_ready;
  logic [31:0] bo_addr, bo_data;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q [16];

  always #2 clk = ~clk;

  sq_burst_writer u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1;
    acc_addr = 32'hE000_0000 | (idx << 2); acc_wdata = d;
    #1;
    while (!acc_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_write = 1'b0;
    exp_q[idx] = d;
  endtask

  task automatic rd(input int idx, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0;
    acc_addr = 32'hE000_0000 | (idx << 2);
    @(posedge clk); #1;
    acc_valid = 1'b0;
    chk(rd_valid == 1'b1, req, {31'd0, rd_valid}, 32'd1);
    chk(rd_data == exp_q[idx], req, rd_data, exp_q[idx]);
  endtask

  task automatic set_hi(input bit sel, input logic [2:0] v);
    @(negedge clk);
    hreg_we = 1'b1; hreg_sel = sel; hreg_wdata = v;
    @(posedge clk); #1;
    hreg_we = 1'b0;
  endtask

  task automatic issue_pf(input logic [31:0] a, input bit xl);
    @(negedge clk);
    pf_valid = 1'b1; pf_addr = a; xlate_mode = xl;
    #1;
    while (!pf_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    pf_valid = 1'b0;
  endtask

  task automatic collect(input logic [31:0] eaddr, input int q, input bit stall,
                         input bit wchk, input string req);
    int beat = 0;
    int cyc  = 0;
    while (beat < 8 && cyc < 200) begin
      @(negedge clk);
      cyc++;
      bo_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (wchk) chk(acc_ready == 1'b0, "R8 write to flushing buffer", {31'd0, acc_ready}, 32'd0);
      if (bo_valid && bo_ready) begin
        chk(bo_data == exp_q[q*8 + beat], req, bo_data, exp_q[q*8 + beat]);
        chk(bo_addr == eaddr, req, bo_addr, eaddr);
        chk(bo_last == (beat == 7), "R3 last flag", {31'd0, bo_last}, {31'd0, beat == 7});
        beat++;
      end
    end
    chk(beat == 8, "R3 beat count", beat, 8);
    @(posedge clk); #1;
    bo_ready = 1'b0;
    chk(busy == 1'b0, "R3 busy after last", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_reset;
    chk(busy == 1'b0,     "R1 busy",     {31'd0, busy}, 0);
    chk(bo_valid == 1'b0, "R1 bo_valid", {31'd0, bo_valid}, 0);
    chk(pf_ready == 1'b1, "R1 pf_ready", {31'd0, pf_ready}, 1);
    chk(rd_valid == 1'b0, "R1 rd_valid", {31'd0, rd_valid}, 0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 16; i++) wr(i, 32'hA500_0000 ^ (i * 32'h0101_0111));
    for (int i = 0; i < 16; i++) rd(i, "R2 readback");
  endtask

  task automatic t_flush_reset_hi;
    logic [31:0] a = 32'hE123_4567;
    issue_pf(a, 1'b0);
    collect(a & 32'h03FF_FFE0, 1, 1'b0, 1'b0, "R1 R4 q1 flush, hi zero");
  endtask

  task automatic t_hi_regs;
    logic [31:0] a0 = 32'hE0AB_CD80;
    logic [31:0] a1 = 32'hE3AB_CDE4;
    set_hi(1'b0, 3'd2);
    set_hi(1'b1, 3'd5);
    issue_pf(a0, 1'b0);
    collect((32'd2 << 26) | (a0 & 32'h03FF_FFE0), 0, 1'b0, 1'b0, "R9 R4 q0 hi=2");
    issue_pf(a1, 1'b0);
    collect((32'd5 << 26) | (a1 & 32'h03FF_FFE0), 1, 1'b0, 1'b0, "R9 R4 q1 hi=5");
  endtask

  task automatic t_xlate_stall;
    logic [31:0] a = 32'hFEDC_BA9F;
    issue_pf(a, 1'b1);
    collect(a & 32'h1FFF_FFE0, 0, 1'b1, 1'b0, "R5 R6 translated stalled");
  endtask

  task automatic t_double_pf;
    logic [31:0] a = 32'hE000_1100;
    logic [31:0] b = 32'hE000_2220;
    issue_pf(a, 1'b0);
    @(negedge clk);
    pf_valid = 1'b1; pf_addr = b; xlate_mode = 1'b0;
    #1;
    chk(pf_ready == 1'b0, "R7 held off", {31'd0, pf_ready}, 0);
    chk(busy == 1'b1, "R7 busy", {31'd0, busy}, 1);
    collect((32'd2 << 26) | (a & 32'h03FF_FFE0), 0, 1'b1, 1'b0, "R7 first flush");
    @(negedge clk); #1;
    chk(pf_ready == 1'b1, "R7 ready after", {31'd0, pf_ready}, 1);
    @(posedge clk); #1;
    pf_valid = 1'b0;
    collect((32'd5 << 26) | (b & 32'h03FF_FFE0), 1, 1'b0, 1'b0, "R7 second flush");
  endtask

  task automatic t_write_during_flush;
    logic [31:0] a = 32'hE000_3300;
    issue_pf(a, 1'b0);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1;
    acc_addr = 32'hE000_0000 | (11 << 2); acc_wdata = 32'h1111_BEEF;
    #1;
    chk(acc_ready == 1'b1, "R8 other buffer open", {31'd0, acc_ready}, 1);
    @(posedge clk); #1;
    exp_q[11] = 32'h1111_BEEF;
    acc_addr = 32'hE000_0000 | (2 << 2); acc_wdata = 32'h2222_CAFE;
    collect((32'd2 << 26) | (a & 32'h03FF_FFE0), 0, 1'b1, 1'b1, "R8 flush data intact");
    @(negedge clk); #1;
    chk(acc_ready == 1'b1, "R8 write released", {31'd0, acc_ready}, 1);
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_write = 1'b0;
    exp_q[2] = 32'h2222_CAFE;
    rd(2, "R8 late write landed");
    rd(11, "R8 other buffer write");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    acc_valid = 0; acc_write = 0; acc_addr = 0; acc_wdata = 0;
    pf_valid = 0; pf_addr = 0; xlate_mode = 0;
    hreg_we = 0; hreg_sel = 0; hreg_wdata = 0; bo_ready = 0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_flush_reset_hi();
    t_hi_regs();
    t_xlate_stall();
    t_double_pf();
    t_write_during_flush();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule